// File: doc/BRIEF.md
# Edge-latched interrupt status controller

The block watches six level signals, typically parallel-port pins or counter outputs, and captures a rising edge on each into a sticky status bit. It captures only while the matching bit of an enable register is set. Each source passes through a synchroniser before edge detection, so the source pins may be asynchronous to the block clock.

A single interrupt line goes high when the status word leaves the all-zero state. It stays high while any status bit is set. The line cannot signal again until the status word has been back to zero for at least one cycle. There is no acknowledge register. Software clears a status bit by writing 0 to its enable bit, and then sets the enable bit again to re-arm that source.

A channel-list register selects up to six status bits. A read port returns those bits packed into a 16-bit word, in list order. All registers sit on a small word-wide register bus that has a combinational read path.

Top module: `irq_latch_ctrl`

## Requirements
- R1: After reset, the enable register, the status register and the channel list all read 0, and `irq_o` is low.
- R2: A 0-to-1 transition on `src_i[k]` sets status bit k while enable bit k is 1. The status bit is visible on the bus 3 clock edges after the input changes. It stays set after the source falls.
- R3: A rising edge on a source whose enable bit is 0 leaves its status bit at 0. Enabling a source while its level is already high does not set its status bit, because no edge occurred.
- R4: A bus write to the enable register clears, at the same clock edge, every status bit whose new enable bit is 0. Status bits whose enable bit remains 1 keep their value.
- R5: A source edge that reaches the status stage in the same cycle as a write that clears its enable bit does not set the status bit.
- R6: `irq_o` rises one clock edge after the status word goes from zero to non-zero. It stays high while the status word is non-zero, including when further bits are set.
- R7: `irq_o` falls one clock edge after the status word becomes zero. A later zero-to-non-zero transition raises it again.
- R8: The status register is read-only. A bus write to address 1 changes no register.
- R9: Register map: address 0 is the enable register (bits [5:0]); address 1 is the status register (bits [5:0]); address 2 is the channel list; address 3 is the packed read. In the channel list, bits [2:0] hold the length and entry j (source index) occupies bits [3j+5:3j+3]. Bit j of the packed word equals the status bit named by entry j, for every j below the length.
- R10: A length above 6 acts as 6. Packed bits at or above the effective length read 0. An entry value of 6 or 7 reads 0. Bits [15:6] of the packed word are always 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| src_i | input | 6 | Interrupt source levels, may be asynchronous |
| bus_we_i | input | 1 | Register write strobe |
| bus_addr_i | input | 2 | Register address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for `bus_addr_i`, combinational |
| irq_o | output | 1 | Interrupt level |

## Verification
The bench builds the block with its default parameters: six sources, a two-stage synchroniser and a 16-bit packed word. With these values, the 3-bit list entries can name the two non-existent sources 6 and 7, and the 3-bit length field can hold 7, one above the source count. The clamp and out-of-range reads can therefore be reached from the bus. Because the edge path has a fixed depth, the bench can place an enable-clearing write on the exact edge where a source transition reaches the status stage, which exercises that race directly.

// File: rtl/irq_latch_pkg.sv
package irq_latch_pkg;
  localparam int unsigned DEF_NUM_SRC = 6;
  localparam int unsigned DEF_PACK_W  = 16;
  localparam int unsigned DEF_DATA_W  = 32;

  typedef enum logic [1:0] {
    REG_ENABLE = 2'd0,
    REG_STATUS = 2'd1,
    REG_CHLIST = 2'd2,
    REG_PACKED = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/irq_src_sync.sv
module irq_src_sync #(
  parameter int unsigned N      = 6,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] src_i,
  output logic [N-1:0] rise_o
);
  logic [N-1:0] pipe_q [STAGES];
  logic [N-1:0] prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < STAGES; s++) pipe_q[s] <= '0;
      prev_q <= '0;
    end else begin
      pipe_q[0] <= src_i;
      for (int s = 1; s < STAGES; s++) pipe_q[s] <= pipe_q[s-1];
      prev_q <= pipe_q[STAGES-1];
    end
  end

  assign rise_o = pipe_q[STAGES-1] & ~prev_q;

  // an edge indication lasts exactly one cycle
  p_rise_single_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|rise_o) |=> ((rise_o & $past(rise_o)) == '0));
endmodule

// File: rtl/irq_status_bank.sv
module irq_status_bank #(
  parameter int unsigned N = 6
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_we_i,
  input  logic [N-1:0] en_wdata_i,
  input  logic [N-1:0] rise_i,
  output logic [N-1:0] en_o,
  output logic [N-1:0] status_o
);
  logic [N-1:0] en_q, en_d;
  logic [N-1:0] status_q, status_d;

  // set needs enable before and after this edge; disabling clears
  always_comb begin
    en_d     = en_we_i ? en_wdata_i : en_q;
    status_d = (status_q | (rise_i & en_q)) & en_d;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q     <= '0;
      status_q <= '0;
    end else begin
      en_q     <= en_d;
      status_q <= status_d;
    end
  end

  assign en_o     = en_q;
  assign status_o = status_q;

  p_edge_sets_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_we_i && |(rise_i & en_o)) |=>
      ((status_o & $past(rise_i & en_o)) == $past(rise_i & en_o)));

  p_set_needs_en_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(rise_i & ~en_o)) |=> ((status_o & ~$past(status_o) & $past(rise_i & ~en_o)) == '0));

  p_clear_on_disable_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_we_i |=> ((status_o & ~$past(en_wdata_i)) == '0));

  p_status_only_grows_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_we_i |=> ((~status_o & $past(status_o)) == '0));
endmodule

// File: rtl/irq_level_gen.sv
module irq_level_gen #(
  parameter int unsigned N = 6
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] status_i,
  output logic         irq_o
);
  logic armed_q, irq_q;
  logic any_set;

  assign any_set = |status_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q <= 1'b1;
      irq_q   <= 1'b0;
    end else if (!any_set) begin
      armed_q <= 1'b1;
      irq_q   <= 1'b0;
    end else if (armed_q) begin
      armed_q <= 1'b0;
      irq_q   <= 1'b1;
    end
  end

  assign irq_o = irq_q;

  p_rise_after_set_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> $past(any_set));

  p_hold_while_set_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && any_set) |=> irq_o);

  p_drop_on_zero_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !any_set |=> !irq_o);
endmodule

// File: rtl/irq_pack.sv
module irq_pack #(
  parameter int unsigned N     = 6,
  parameter int unsigned OUT_W = 16,
  parameter int unsigned CH_W  = $clog2(N),
  parameter int unsigned LEN_W = $clog2(N + 1),
  parameter int unsigned LIST_W = LEN_W + N * CH_W
) (
  input  logic [LIST_W-1:0] list_i,
  input  logic [N-1:0]      status_i,
  output logic [OUT_W-1:0]  packed_o
);
  localparam int unsigned SPAN = 1 << CH_W;
  localparam logic [LEN_W-1:0] MAX_LEN = LEN_W'(N);

  logic [SPAN-1:0]  padded;
  logic [LEN_W-1:0] len_raw, len_eff;

  assign padded  = SPAN'(status_i);
  assign len_raw = list_i[LEN_W-1:0];
  assign len_eff = (len_raw > MAX_LEN) ? MAX_LEN : len_raw;

  for (genvar k = 0; k < OUT_W; k++) begin : g_bit
    if (k < N) begin : g_live
      localparam logic [LEN_W-1:0] KV = LEN_W'(k);
      logic [CH_W-1:0] sel;
      assign sel         = list_i[LEN_W + k*CH_W +: CH_W];
      assign packed_o[k] = (KV < len_eff) ? padded[sel] : 1'b0;
    end else begin : g_dead
      assign packed_o[k] = 1'b0;
    end
  end

  always_comb begin
    a_len_bound_r10: assert (len_eff <= MAX_LEN);
  end
endmodule

// File: rtl/irq_latch_ctrl.sv
module irq_latch_ctrl
  import irq_latch_pkg::*;
#(
  parameter int unsigned NUM_SRC     = DEF_NUM_SRC,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned PACK_W      = DEF_PACK_W,
  parameter int unsigned DATA_W      = DEF_DATA_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic               bus_we_i,
  input  logic [1:0]         bus_addr_i,
  input  logic [DATA_W-1:0]  bus_wdata_i,
  output logic [DATA_W-1:0]  bus_rdata_o,
  output logic               irq_o
);
  localparam int unsigned CH_W   = $clog2(NUM_SRC);
  localparam int unsigned LEN_W  = $clog2(NUM_SRC + 1);
  localparam int unsigned LIST_W = LEN_W + NUM_SRC * CH_W;

  reg_sel_e              sel;
  logic                  en_we, list_we;
  logic [NUM_SRC-1:0]    rise, en, status;
  logic [LIST_W-1:0]     list_q;
  logic [PACK_W-1:0]     packed_w;

  assign sel     = reg_sel_e'(bus_addr_i);
  assign en_we   = bus_we_i && (sel == REG_ENABLE);
  assign list_we = bus_we_i && (sel == REG_CHLIST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      list_q <= '0;
    else if (list_we) list_q <= bus_wdata_i[LIST_W-1:0];
  end

  irq_src_sync #(.N(NUM_SRC), .STAGES(SYNC_STAGES)) i_sync (
    .clk_i, .rst_ni, .src_i, .rise_o(rise)
  );

  irq_status_bank #(.N(NUM_SRC)) i_bank (
    .clk_i, .rst_ni,
    .en_we_i(en_we), .en_wdata_i(bus_wdata_i[NUM_SRC-1:0]),
    .rise_i(rise), .en_o(en), .status_o(status)
  );

  irq_level_gen #(.N(NUM_SRC)) i_irq (
    .clk_i, .rst_ni, .status_i(status), .irq_o
  );

  irq_pack #(.N(NUM_SRC), .OUT_W(PACK_W), .CH_W(CH_W), .LEN_W(LEN_W), .LIST_W(LIST_W)) i_pack (
    .list_i(list_q), .status_i(status), .packed_o(packed_w)
  );

  always_comb begin
    bus_rdata_o = '0;
    unique case (sel)
      REG_ENABLE: bus_rdata_o[NUM_SRC-1:0] = en;
      REG_STATUS: bus_rdata_o[NUM_SRC-1:0] = status;
      REG_CHLIST: bus_rdata_o[LIST_W-1:0]  = list_q;
      REG_PACKED: bus_rdata_o[PACK_W-1:0]  = packed_w;
      default:    bus_rdata_o = '0;
    endcase
  end

  // a status write strobe must not disturb state
  p_status_ro_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_we_i && sel == REG_STATUS) |=> ($stable(en) && $stable(list_q)));
endmodule

// File: tb/test_irq_latch_ctrl.sv
module test_irq_latch_ctrl;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [5:0]  src_i = '0;
  logic        bus_we_i = 1'b0;
  logic [1:0]  bus_addr_i = '0;
  logic [31:0] bus_wdata_i = '0;
  logic [31:0] bus_rdata_o;
  logic        irq_o;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  bit done = 0;

  always #4 clk_i = ~clk_i;

  irq_latch_ctrl i_irq_latch_ctrl (
    .clk_i, .rst_ni, .src_i, .bus_we_i, .bus_addr_i, .bus_wdata_i, .bus_rdata_o, .irq_o
  );

  always @(posedge clk_i) begin
    cyc++;
    if (cyc > 20000 && !done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog: act=%0d exp<=20000 cycles", cyc);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: act=0x%0h exp=0x%0h", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk_i);
    bus_we_i = 1'b1; bus_addr_i = a; bus_wdata_i = d;
    @(negedge clk_i);
    bus_we_i = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk_i);
    bus_addr_i = a;
    #1 d = bus_rdata_o;
  endtask

  task automatic set_src(input logic [5:0] v);
    @(negedge clk_i);
    src_i = v;
    wait_cyc(4);
  endtask

  function automatic logic [31:0] mk_list(input int len, input int e0, e1, e2, e3, e4, e5);
    return 32'(len & 7) | 32'((e0 & 7) << 3) | 32'((e1 & 7) << 6) | 32'((e2 & 7) << 9)
         | 32'((e3 & 7) << 12) | 32'((e4 & 7) << 15) | 32'((e5 & 7) << 18);
  endfunction

  task automatic t_reset;
    logic [31:0] d;
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), d);
      check("R1 reg after reset", d, 32'h0);
    end
    check("R1 irq after reset", 32'(irq_o), 32'h0);
  endtask

  task automatic t_latch;
    logic [31:0] d;
    wr(2'd0, 32'h3F);
    @(negedge clk_i); src_i = 6'h01;
    @(negedge clk_i); @(negedge clk_i);
    rd(2'd1, d);
    check("R2 status after 3 edges", d, 32'h01);
    @(negedge clk_i);
    check("R6 irq one edge after status", 32'(irq_o), 32'h1);
    set_src(6'h00);
    rd(2'd1, d);
    check("R2 status sticky after fall", d, 32'h01);
    set_src(6'h08);
    rd(2'd1, d);
    check("R2 second source", d, 32'h09);
    check("R6 irq held with more bits", 32'(irq_o), 32'h1);
    set_src(6'h00);
    wr(2'd0, 32'h36);
    rd(2'd1, d);
    check("R4 disable clears", d, 32'h00);
    wait_cyc(1);
    check("R7 irq low after zero", 32'(irq_o), 32'h0);
    wr(2'd0, 32'h3F);
  endtask

  task automatic t_disabled;
    logic [31:0] d;
    wr(2'd0, 32'h3E);
    set_src(6'h01);
    rd(2'd1, d);
    check("R3 edge while disabled", d, 32'h00);
    check("R3 no irq", 32'(irq_o), 32'h0);
    wr(2'd0, 32'h3F);
    wait_cyc(4);
    rd(2'd1, d);
    check("R3 enable on high level", d, 32'h00);
    set_src(6'h00);
  endtask

  task automatic t_selective;
    logic [31:0] d;
    set_src(6'h06);
    rd(2'd1, d);
    check("R2 two sources", d, 32'h06);
    wr(2'd0, 32'h3B);
    rd(2'd1, d);
    check("R4 others kept", d, 32'h02);
    check("R6 irq stays", 32'(irq_o), 32'h1);
    rd(2'd0, d);
    check("R9 enable readback", d, 32'h3B);
    wr(2'd0, 32'h00);
    wait_cyc(1);
    check("R7 irq drops", 32'(irq_o), 32'h0);
    set_src(6'h00);
    wr(2'd0, 32'h3F);
    set_src(6'h10);
    check("R7 irq re-raised", 32'(irq_o), 32'h1);
    set_src(6'h00);
    wr(2'd0, 32'h00);
    wr(2'd0, 32'h3F);
    wait_cyc(2);
  endtask

  task automatic t_race;
    logic [31:0] d;
    @(negedge clk_i); src_i = 6'h20;
    @(negedge clk_i);
    @(negedge clk_i);
    bus_we_i = 1'b1; bus_addr_i = 2'd0; bus_wdata_i = 32'h1F;
    @(negedge clk_i);
    bus_we_i = 1'b0;
    wr(2'd0, 32'h3F);
    wait_cyc(3);
    rd(2'd1, d);
    check("R5 edge on clearing write", d, 32'h00);
    check("R5 no irq", 32'(irq_o), 32'h0);
    set_src(6'h00);
  endtask

  task automatic t_readonly;
    logic [31:0] d;
    wr(2'd1, 32'h3F);
    rd(2'd1, d);
    check("R8 status write ignored (zero)", d, 32'h00);
    set_src(6'h04);
    wr(2'd1, 32'h00);
    rd(2'd1, d);
    check("R8 status write ignored (set)", d, 32'h04);
    rd(2'd0, d);
    check("R8 enable untouched", d, 32'h3F);
    rd(2'd2, d);
    check("R8 list untouched", d, 32'h00);
    set_src(6'h00);
    wr(2'd0, 32'h00);
    wr(2'd0, 32'h3F);
  endtask

  task automatic t_pack;
    logic [31:0] d;
    set_src(6'h0B);
    rd(2'd1, d);
    check("R2 pattern 0x0B", d, 32'h0B);
    wr(2'd2, mk_list(6, 5, 4, 3, 2, 1, 0));
    rd(2'd3, d);
    check("R9 reversed list", d, 32'h34);
    wr(2'd2, mk_list(3, 3, 0, 1, 3, 0, 0));
    rd(2'd3, d);
    check("R9 short list", d, 32'h07);
    rd(2'd2, d);
    check("R9 list readback", d, mk_list(3, 3, 0, 1, 3, 0, 0));
    wr(2'd2, mk_list(7, 0, 1, 2, 3, 4, 5));
    rd(2'd3, d);
    check("R10 length clamp", d, 32'h0B);
    wr(2'd2, mk_list(2, 7, 3, 0, 0, 0, 0));
    rd(2'd3, d);
    check("R10 entry out of range", d, 32'h02);
    wr(2'd2, mk_list(6, 6, 6, 6, 6, 6, 6));
    rd(2'd3, d);
    check("R10 all entries absent", d, 32'h00);
    wr(2'd2, mk_list(0, 0, 1, 3, 0, 0, 0));
    rd(2'd3, d);
    check("R10 zero length", d, 32'h00);
    set_src(6'h00);
  endtask

  initial begin
    wait_cyc(3);
    rst_ni = 1'b1;
    t_reset();
    t_latch();
    t_disabled();
    t_selective();
    t_race();
    t_readonly();
    t_pack();
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule